// File: doc/BRIEF.md
# NAND Page Read Sequencer

This block is a host-side controller that fetches data from a small-page NAND flash over the flash's 8-bit asynchronous bus. A read request carries a 19-bit row, an 8-bit column, a half-select flag and a sequential flag. The block drives chip enable, the command and address latch enables and the write strobe. It issues the read command byte followed by four address bytes. It then waits for the ready/busy line and pulses the read strobe once per byte. Each byte is handed to the user over a valid/ready byte stream, and the last byte of every page is marked.

A page holds 528 bytes. The half-select flag picks command 00h, which starts in the lower 256 bytes, or 01h, which starts 256 bytes higher. In sequential mode the flash moves to the next page by itself after the last column. The block waits for the load again and keeps streaming from column 0. It stops after the last of the 32 pages in a block. The user can abort at any time by pulsing `abort`. An abort during the array load raises chip enable and flags the transfer as discarded. Bus phase lengths come from four programmable cycle counts.

Top module: `nand_page_reader`

## Requirements
- R1: After reset, chip enable, write strobe and read strobe are high, the latch enables are low, `req_ready` is 1 and `dout_valid` is 0.
- R2: A command byte (00h when `req_half`=0, 01h when `req_half`=1) is driven with the command latch high and the write strobe low for the programmed write-pulse count of cycles.
- R3: Exactly four address bytes follow, with the address latch high, in the order column[7:0], row[7:0], row[15:8], then row[18:16] in bits 2:0 with bits 7:3 zero.
- R4: After the last address byte the block waits the programmed busy-delay count and then until `nand_rb_n` is 1, and the read strobe is never low while `nand_rb_n` is 0.
- R5: Bytes are delivered in column order from the start column (`req_col`, plus 256 when `req_half`=1) through column 527, one read-strobe pulse per byte, and `dout_last` is 1 on the column-527 byte.
- R6: With `req_seq`=1 the read continues on the next row at column 0 after a fresh busy wait. It ends after a page whose row bits 4:0 are all ones. With `req_seq`=0 it ends after one page.
- R7: An `abort` pulse while waiting for the array load returns the block to idle with chip enable high in the next cycle, pulses `xfer_discard` for one cycle, and delivers no data.
- R8: The command byte is left out and only the address bytes are sent when `req_half`=0 and the previous read ended normally. After reset, after an abort, or when `req_half`=1, the command is always sent.
- R9: While `dout_valid` is 1 and `dout_ready` is 0, `dout_data` holds its value and no further read-strobe pulse occurs.
- R10: `cfg_wr` with `cfg_sel` 0, 1, 2 or 3 sets the write-pulse, read-pulse, read-high and busy-delay counts in cycles. A programmed 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write one timing count |
| cfg_sel | input | 2 | Count select: 0 write pulse, 1 read pulse, 2 read high, 3 busy delay |
| cfg_data | input | 16 | Count value in cycles |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Block idle and accepting a request |
| req_row | input | 19 | Row (page) address |
| req_col | input | 8 | Start column within the selected half |
| req_half | input | 1 | 0: command 00h, 1: command 01h |
| req_seq | input | 1 | Continue through following pages of the block |
| abort | input | 1 | End the current read with chip enable high |
| dout_valid | output | 1 | Output byte valid |
| dout_ready | input | 1 | User accepts the byte |
| dout_data | output | 8 | Data byte |
| dout_last | output | 1 | Byte is column 527 of its page |
| xfer_discard | output | 1 | One-cycle pulse: load aborted, transfer dropped |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Bus value driven to the flash |
| nand_io_oe | output | 1 | Bus drive enable |
| nand_io_in | input | 8 | Bus value from the flash |
| nand_rb_n | input | 1 | Ready (1) / busy (0) |

## Verification
The read path is tried with a start at column 0, starts mid-half and at the top of the lower half, a start in the upper half, a sequential run that begins in the next-to-last page of a block, and a sequential run that begins on the last page. Together these separate the column offset, the page-advance path and the block-end stop. The runs alternate between a free-flowing consumer and one that stalls every third cycle, which shows that a stall holds the byte and does not lose or repeat strobes. Back-to-back requests with and without a change of half, and one after an abort, show when the command byte may be skipped.

// File: rtl/nrd_pkg.sv
// Shared types for the NAND page read sequencer.
// Assumes: one read in flight at a time, states encoded in 4 bits.
package nrd_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_CMD_LO, ST_CMD_HI, ST_ADR_LO, ST_ADR_HI,
        ST_WB, ST_RB, ST_RE_LO, ST_HOLD, ST_RE_HI
    } nrd_state_e;

    // Index of each timing count in the programmable bank.
    typedef enum logic [1:0] {
        TI_WP  = 2'd0,
        TI_RP  = 2'd1,
        TI_REH = 2'd2,
        TI_WB  = 2'd3
    } nrd_tsel_e;

    localparam logic [7:0] CMD_LOWER = 8'h00;
    localparam logic [7:0] CMD_UPPER = 8'h01;
    localparam int         ADDR_CYCLES = 4;
endpackage

// File: rtl/nrd_cfg.sv
// Bank of four programmable bus-timing counts (cycles).
// Assumes: a write lands in the register chosen by sel on the next edge.
module nrd_cfg #(
    parameter int TW       = 16,
    parameter int DEF_WP   = 2,
    parameter int DEF_RP   = 2,
    parameter int DEF_REH  = 1,
    parameter int DEF_WB   = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [1:0]            sel,
    input  logic [TW-1:0]         data,
    output logic [3:0][TW-1:0]    vals
);
    function automatic logic [TW-1:0] def_of(input int i);
        case (i)
            0:       def_of = TW'(DEF_WP);
            1:       def_of = TW'(DEF_RP);
            2:       def_of = TW'(DEF_REH);
            default: def_of = TW'(DEF_WB);
        endcase
    endfunction

    for (genvar g = 0; g < 4; g++) begin : g_reg
        // Hold one timing count, reloaded from its default on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                vals[g] <= def_of(g);
            else if (wr && sel == 2'(g))
                vals[g] <= data;
        end
    end
endmodule

// File: rtl/nrd_timer.sv
// Phase timer: a load of N makes done rise in the Nth cycle after the load.
// Assumes: a loaded value of zero is treated as one.
module nrd_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] val,
    output logic          done
);
    logic [TW-1:0] cnt;

    // Count down from the loaded length and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= (val == '0) ? TW'(1) : val;
        else if (cnt != '0)
            cnt <= cnt - TW'(1);
    end

    assign done = (cnt == TW'(1));
endmodule

// File: rtl/nrd_addr.sv
// Row and column tracker for one read: loads the start point, steps the
// column per byte, advances the row within a block and gives address bytes.
// Assumes: ROW_W <= 24 and the page is longer than 256 bytes.
module nrd_addr #(
    parameter int ROW_W      = 19,
    parameter int PAGE_BYTES = 528,
    parameter int BLK_PAGES  = 32,
    localparam int COL_W     = $clog2(PAGE_BYTES),
    localparam int PG_BITS   = $clog2(BLK_PAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ROW_W-1:0] row_in,
    input  logic [7:0]       col_in,
    input  logic             half,
    input  logic             col_inc,
    input  logic             page_adv,
    input  logic [1:0]       byte_idx,
    output logic             last_col,
    output logic             blk_end,
    output logic [7:0]       abyte
);
    localparam int HALF_OFS = 256;
    localparam int PAD_W    = 24 - ROW_W;

    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
    logic [23:0]      row_pad;

    // Track the current column and row across bytes and pages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col <= '0;
            row <= '0;
        end else if (load) begin
            col <= half ? COL_W'(HALF_OFS) + COL_W'(col_in) : COL_W'(col_in);
            row <= row_in;
        end else if (page_adv) begin
            col <= '0;
            row <= row + ROW_W'(1);
        end else if (col_inc) begin
            col <= col + COL_W'(1);
        end
    end

    assign last_col = (col == COL_W'(PAGE_BYTES - 1));
    assign blk_end  = &row[PG_BITS-1:0];

    if (PAD_W > 0) begin : g_pad
        assign row_pad = {{PAD_W{1'b0}}, row};
    end else begin : g_nopad
        assign row_pad = row;
    end

    // Pick the address byte for the current address cycle.
    always_comb begin
        case (byte_idx)
            2'd0:    abyte = col[7:0];
            2'd1:    abyte = row_pad[7:0];
            2'd2:    abyte = row_pad[15:8];
            default: abyte = row_pad[23:16];
        endcase
    end

    p_col_in_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
        col < COL_W'(PAGE_BYTES));

    p_no_cross_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        page_adv |-> !blk_end);
endmodule

// File: rtl/nand_page_reader.sv
// NAND page read sequencer: issues command and address bytes, waits for
// the array load, strobes bytes out to a valid/ready stream and optionally
// continues page by page until the end of a block.
// Assumes: nand_rb_n is synchronous to clk; bus pins decode from the state.
module nand_page_reader
    import nrd_pkg::*;
#(
    parameter int ROW_W      = 19,
    parameter int TW         = 16,
    parameter int PAGE_BYTES = 528,
    parameter int BLK_PAGES  = 32,
    parameter int DEF_WP     = 2,
    parameter int DEF_RP     = 2,
    parameter int DEF_REH    = 1,
    parameter int DEF_WB     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_sel,
    input  logic [TW-1:0]    cfg_data,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ROW_W-1:0] req_row,
    input  logic [7:0]       req_col,
    input  logic             req_half,
    input  logic             req_seq,
    input  logic             abort,
    output logic             dout_valid,
    input  logic             dout_ready,
    output logic [7:0]       dout_data,
    output logic             dout_last,
    output logic             xfer_discard,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_io_out,
    output logic             nand_io_oe,
    input  logic [7:0]       nand_io_in,
    input  logic             nand_rb_n
);
    localparam logic [1:0] LAST_ADDR = 2'(ADDR_CYCLES - 1);

    nrd_state_e          state, nxt;
    logic [1:0]          aidx;
    logic                half_q, seq_q, ptr_main;
    logic [7:0]          data_q;
    logic [3:0][TW-1:0]  tvals;
    logic                tmr_load, tmr_done;
    logic [TW-1:0]       tmr_val;
    logic                last_col, blk_end;
    logic [7:0]          abyte;
    logic                accept, load_req, col_inc, page_adv, aborting;

    nrd_cfg #(
        .TW(TW), .DEF_WP(DEF_WP), .DEF_RP(DEF_RP),
        .DEF_REH(DEF_REH), .DEF_WB(DEF_WB)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel),
        .data(cfg_data), .vals(tvals)
    );

    nrd_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val),
        .done(tmr_done)
    );

    nrd_addr #(
        .ROW_W(ROW_W), .PAGE_BYTES(PAGE_BYTES), .BLK_PAGES(BLK_PAGES)
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .load(load_req), .row_in(req_row),
        .col_in(req_col), .half(req_half), .col_inc(col_inc),
        .page_adv(page_adv), .byte_idx(aidx), .last_col(last_col),
        .blk_end(blk_end), .abyte(abyte)
    );

    assign aborting = abort && (state != ST_IDLE);
    assign load_req = (state == ST_IDLE) && req_valid;
    assign accept   = (state == ST_HOLD) && dout_ready && !aborting;
    assign col_inc  = accept && !last_col;
    assign page_adv = accept && last_col && seq_q && !blk_end;

    // Choose the next bus phase.
    always_comb begin
        nxt = state;
        if (aborting) begin
            nxt = ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:   if (req_valid)
                               nxt = (ptr_main && !req_half) ? ST_ADR_LO : ST_CMD_LO;
                ST_CMD_LO: if (tmr_done) nxt = ST_CMD_HI;
                ST_CMD_HI: if (tmr_done) nxt = ST_ADR_LO;
                ST_ADR_LO: if (tmr_done) nxt = ST_ADR_HI;
                ST_ADR_HI: if (tmr_done) nxt = (aidx == LAST_ADDR) ? ST_WB : ST_ADR_LO;
                ST_WB:     if (tmr_done) nxt = ST_RB;
                ST_RB:     if (nand_rb_n) nxt = ST_RE_LO;
                ST_RE_LO:  if (tmr_done) nxt = ST_HOLD;
                ST_HOLD:   if (dout_ready)
                               nxt = !last_col ? ST_RE_HI :
                                     (seq_q && !blk_end) ? ST_WB : ST_IDLE;
                ST_RE_HI:  if (tmr_done) nxt = ST_RE_LO;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    // Start a fresh phase timer on every change of phase.
    always_comb begin
        tmr_load = (nxt != state);
        case (nxt)
            ST_WB:    tmr_val = tvals[TI_WB];
            ST_RE_LO: tmr_val = tvals[TI_RP];
            ST_RE_HI: tmr_val = tvals[TI_REH];
            default:  tmr_val = tvals[TI_WP];
        endcase
    end

    // Advance the phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Count address cycles within the address phase.
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_IDLE)
            aidx <= '0;
        else if (state == ST_ADR_HI && tmr_done && nxt == ST_ADR_LO)
            aidx <= aidx + 2'd1;
    end

    // Latch the request mode flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            seq_q  <= 1'b0;
        end else if (load_req) begin
            half_q <= req_half;
            seq_q  <= req_seq;
        end
    end

    // Remember whether the flash pointer is known to sit on the lower half.
    always_ff @(posedge clk) begin
        if (!rst_n || aborting)
            ptr_main <= 1'b0;
        else if (accept && last_col && !(seq_q && !blk_end))
            ptr_main <= 1'b1;
    end

    // Capture the bus byte at the end of the read-strobe low phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (state == ST_RE_LO && tmr_done)
            data_q <= nand_io_in;
    end

    // Flag a load that was cut short by an abort.
    always_ff @(posedge clk) begin
        if (!rst_n)
            xfer_discard <= 1'b0;
        else
            xfer_discard <= aborting && (state == ST_WB || state == ST_RB);
    end

    assign req_ready   = (state == ST_IDLE);
    assign dout_valid  = (state == ST_HOLD);
    assign dout_data   = data_q;
    assign dout_last   = (state == ST_HOLD) && last_col;
    assign nand_ce_n   = (state == ST_IDLE);
    assign nand_cle    = (state == ST_CMD_LO) || (state == ST_CMD_HI);
    assign nand_ale    = (state == ST_ADR_LO) || (state == ST_ADR_HI);
    assign nand_we_n   = !((state == ST_CMD_LO) || (state == ST_ADR_LO));
    assign nand_re_n   = (state != ST_RE_LO);
    assign nand_io_oe  = nand_cle || nand_ale;
    assign nand_io_out = nand_cle ? (half_q ? CMD_UPPER : CMD_LOWER) : abyte;

    p_re_only_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> nand_rb_n);

    p_stall_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid && !dout_ready && !abort) |=> (dout_valid && $stable(dout_data)));

    p_discard_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_discard |-> (nand_ce_n && !dout_valid));

    p_cmd_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        nand_cle |-> (nand_io_out == CMD_LOWER || nand_io_out == CMD_UPPER));

    p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));
endmodule

// File: tb/nand_page_reader_test.sv
module nand_page_reader_test;
    localparam int BUSY = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [18:0] req_row = '0;
    logic [7:0]  req_col = '0;
    logic        req_half = 1'b0;
    logic        req_seq = 1'b0;
    logic        abort = 1'b0;
    logic        dout_valid, dout_last, xfer_discard;
    logic        dout_ready = 1'b1;
    logic [7:0]  dout_data;
    logic        ce_n, cle, ale, we_n, re_n, io_oe, rb_n;
    logic [7:0]  io_out, io_in;

    int tests = 0, fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    nand_page_reader uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .req_valid(req_valid), .req_ready(req_ready),
        .req_row(req_row), .req_col(req_col), .req_half(req_half),
        .req_seq(req_seq), .abort(abort), .dout_valid(dout_valid),
        .dout_ready(dout_ready), .dout_data(dout_data), .dout_last(dout_last),
        .xfer_discard(xfer_discard), .nand_ce_n(ce_n), .nand_cle(cle),
        .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n),
        .nand_io_out(io_out), .nand_io_oe(io_oe), .nand_io_in(io_in),
        .nand_rb_n(rb_n)
    );

    // Flash model
    function automatic logic [7:0] pat(input logic [18:0] r, input logic [9:0] c);
        return r[7:0] ^ c[7:0] ^ {6'b0, c[9:8]} ^ 8'h5A;
    endfunction

    logic [7:0]  m_a [4];
    logic [1:0]  m_aidx = '0;
    logic        m_ptr2 = 1'b0;
    logic [7:0]  m_cmd = '0;
    int          m_cmdcnt = 0;
    logic [18:0] m_row = '0;
    logic [9:0]  m_col = '0;
    int          m_busy = 0;
    logic        pwe = 1'b1, pre = 1'b1;
    int          busy_re_err = 0;

    assign rb_n  = (m_busy == 0);
    assign io_in = pat(m_row, m_col);

    always @(posedge clk) begin
        pwe <= we_n;
        pre <= re_n;
        if (!re_n && m_busy != 0) busy_re_err <= busy_re_err + 1;
        if (ce_n) begin
            m_aidx <= '0;
            m_ptr2 <= 1'b0;
            m_busy <= 0;
        end else begin
            if (m_busy != 0) m_busy <= m_busy - 1;
            if (!pwe && we_n) begin
                if (cle) begin
                    m_cmd <= io_out;
                    m_cmdcnt <= m_cmdcnt + 1;
                    m_ptr2 <= (io_out == 8'h01);
                    m_aidx <= '0;
                end else if (ale) begin
                    m_a[m_aidx] <= io_out;
                    m_aidx <= m_aidx + 2'd1;
                    if (m_aidx == 2'd3) begin
                        m_row <= {io_out[2:0], m_a[2], m_a[1]};
                        m_col <= m_ptr2 ? 10'd256 + {2'b0, m_a[0]} : {2'b0, m_a[0]};
                        m_busy <= BUSY;
                    end
                end
            end
            if (!pre && re_n) begin
                if (m_col == 10'd527) begin
                    if (m_row[4:0] != 5'h1F) begin
                        m_row <= m_row + 19'd1;
                        m_col <= '0;
                        m_busy <= BUSY;
                    end
                end else begin
                    m_col <= m_col + 10'd1;
                end
            end
        end
    end

    // Monitors: write-pulse width and stall stability
    int we_run = 0, we_w = 0, stall_err = 0;
    logic prev_stall = 1'b0;
    logic [7:0] prev_data = '0;
    always @(negedge clk) begin
        if (!we_n) we_run <= we_run + 1;
        else if (we_run > 0) begin
            we_w <= we_run;
            we_run <= 0;
        end
        if (prev_stall && !(dout_valid && dout_data == prev_data && re_n))
            stall_err <= stall_err + 1;
        prev_stall <= dout_valid && !dout_ready && rst_n;
        prev_data <= dout_data;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    task automatic run_read(input logic [18:0] r, input logic [7:0] c, input bit h,
                            input bit s, input bit bp,
                            output int nb, output int nerr, output int npg);
        logic [18:0] er;
        logic [9:0]  ec;
        int cyc;
        nb = 0; nerr = 0; npg = 0; cyc = 0;
        er = r;
        ec = h ? 10'd256 + {2'b0, c} : {2'b0, c};
        @(negedge clk);
        req_row = r; req_col = c; req_half = h; req_seq = s; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) begin
            if (dout_valid && dout_ready) begin
                nb++;
                if (dout_data != pat(er, ec)) nerr++;
                if (dout_last) npg++;
                if (ec == 10'd527) begin
                    ec = '0;
                    er = er + 19'd1;
                end else ec = ec + 10'd1;
            end
            @(negedge clk);
            cyc++;
            dout_ready = bp ? (cyc % 3 != 0) : 1'b1;
        end
        dout_ready = 1'b1;
    endtask

    typedef struct packed {
        logic [18:0] row;
        logic [7:0]  col;
        logic        half;
        logic        seq;
        logic        bp;
        logic        cmd;
        logic [1:0]  pages;
        logic [9:0]  bytes;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{row: 19'h00005, col: 8'd0,   half: 1'b0, seq: 1'b0, bp: 1'b0, cmd: 1'b1, pages: 2'd1, bytes: 10'd528},
        '{row: 19'h00005, col: 8'd10,  half: 1'b0, seq: 1'b0, bp: 1'b1, cmd: 1'b0, pages: 2'd1, bytes: 10'd518},
        '{row: 19'h00007, col: 8'd3,   half: 1'b1, seq: 1'b0, bp: 1'b0, cmd: 1'b1, pages: 2'd1, bytes: 10'd269},
        '{row: 19'h0001E, col: 8'd200, half: 1'b1, seq: 1'b1, bp: 1'b1, cmd: 1'b1, pages: 2'd2, bytes: 10'd600},
        '{row: 19'h0003F, col: 8'd0,   half: 1'b0, seq: 1'b1, bp: 1'b0, cmd: 1'b0, pages: 2'd1, bytes: 10'd528},
        '{row: 19'h4ABCD, col: 8'd255, half: 1'b0, seq: 1'b0, bp: 1'b1, cmd: 1'b0, pages: 2'd1, bytes: 10'd273}
    };

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        int nb, ne, np, c0, saw;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ce_n && we_n && re_n && !cle && !ale && req_ready && !dout_valid,
              "R1 idle outputs", {ce_n, we_n, re_n, cle, ale, req_ready, dout_valid}, 7'b1110010);

        foreach (VEC[i]) begin
            c0 = m_cmdcnt;
            run_read(VEC[i].row, VEC[i].col, VEC[i].half, VEC[i].seq, VEC[i].bp, nb, ne, np);
            check(nb == int'(VEC[i].bytes), "R5/R6 byte count", nb, VEC[i].bytes);
            check(ne == 0, "R5 data order", ne, 0);
            check(np == int'(VEC[i].pages), "R6 page count", np, VEC[i].pages);
            check(m_cmdcnt - c0 == int'(VEC[i].cmd), "R8 command sent", m_cmdcnt - c0, VEC[i].cmd);
            if (VEC[i].cmd)
                check(m_cmd == {7'b0, VEC[i].half}, "R2 command byte", m_cmd, VEC[i].half);
            check(m_a[0] == VEC[i].col && m_a[1] == VEC[i].row[7:0] &&
                  m_a[2] == VEC[i].row[15:8] && m_a[3] == {5'b0, VEC[i].row[18:16]},
                  "R3 address bytes", {m_a[3], m_a[2], m_a[1], m_a[0]},
                  {5'b0, VEC[i].row, VEC[i].col});
            check(ce_n, "R6 read ends with CE high", ce_n, 1);
        end

        // R7 abort during array load
        @(negedge clk);
        req_row = 19'h00100; req_col = 8'd0; req_half = 1'b0; req_seq = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (rb_n) @(negedge clk);
        repeat (5) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check(xfer_discard, "R7 discard pulse", xfer_discard, 1);
        check(ce_n && req_ready, "R7 CE high after abort", ce_n, 1);
        saw = 0;
        repeat (40) begin
            @(negedge clk);
            if (dout_valid) saw++;
        end
        check(saw == 0 && !xfer_discard, "R7 no data after abort", saw, 0);

        // R8 command reissued after abort
        c0 = m_cmdcnt;
        run_read(19'h00100, 8'd250, 1'b0, 1'b0, 1'b0, nb, ne, np);
        check(m_cmdcnt - c0 == 1, "R8 command after abort", m_cmdcnt - c0, 1);
        check(nb == 278 && ne == 0, "R5 read after abort", nb, 278);

        // R10 and R2: programmed write-pulse length
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 2'd0; cfg_data = 16'd5;
        @(negedge clk);
        cfg_wr = 1'b0;
        run_read(19'h00009, 8'd0, 1'b1, 1'b0, 1'b0, nb, ne, np);
        check(we_w == 5, "R10 write pulse 5", we_w, 5);
        check(nb == 272 && ne == 0, "R10 data with slow pulses", nb, 272);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 2'd0; cfg_data = 16'd0;
        @(negedge clk);
        cfg_sel = 2'd1; cfg_data = 16'd4;
        @(negedge clk);
        cfg_wr = 1'b0;
        run_read(19'h0000A, 8'd100, 1'b1, 1'b0, 1'b1, nb, ne, np);
        check(we_w == 1, "R10 zero acts as one", we_w, 1);
        check(nb == 172 && ne == 0, "R10 data with long read pulse", nb, 172);

        // R4 and R9 monitors
        check(busy_re_err == 0, "R4 no read strobe while busy", busy_re_err, 0);
        check(stall_err == 0, "R9 stalled byte held", stall_err, 0);
        summary();
    end
endmodule